// File: doc/BRIEF.md
# Merge Candidate Index Mapper

This block resolves the merge-mode motion parameters of one prediction unit. A request carries availability flags and motion data for seven neighbours (five spatial, two temporal), the slice kind, the count of usable reference pictures and a merge index. The block builds a five-slot candidate list in which every slot names where its motion comes from. A slot can point at an original neighbour, at a pair of neighbours (one per direction) or at the zero vector. Only the slot picked by the merge index is carried forward. Its two source indices then drive one narrow 8-way selector per prediction direction, so no full candidate records are moved through a list multiplexer.

A request is a single-cycle pulse on `in_valid`. The chosen parameters appear on the outputs together with a one-cycle `out_valid` strobe two clock edges later. They stay unchanged until the next strobe. A new request may be issued on every cycle. Neighbour fetching and temporal vector scaling take place upstream of this block.

Motion vectors travel as 32-bit words. Bits [15:0] hold the horizontal component and bits [31:16] hold the vertical component.

Top module: `merge_index_mapper`

## Requirements
- R1: After reset `out_valid` and every data output are 0. Each cycle with `in_valid` high produces exactly one `out_valid` pulse two rising edges later, and `out_valid` is never high at any other time.
- R2: The list opens with the available neighbours in input index order: 0 above-right, 1 below-left, 2 left, 3 above, 4 above-left, 5 temporal bottom-right, 6 temporal centre. Only the first five available neighbours are taken.
- R3: `merge_idx` selects list slot `merge_idx`. Any value above 4 selects slot 4.
- R4: Paired candidates are appended only when `slice_bi` is 1, at least two originals are present and the list is not yet full. List positions are examined as (first,second) pairs in the order (0,1),(1,0),(0,2),(2,0),(1,2),(2,1),(0,3),(3,0),(1,3),(3,1),(2,3),(3,2). Examination stops after n·(n−1) pairs, where n is the number of originals, or earlier once the list holds five entries.
- R5: A pair is skipped unless the first neighbour predicts from list 0, the second neighbour predicts from list 1, and the two differ in reference index (list-0 index of the first against list-1 index of the second) or in motion vector.
- R6: A paired entry sets both prediction flags to 1. It takes its list-0 reference index and vector from the first neighbour and its list-1 reference index and vector from the second.
- R7: Zero entries fill the remaining slots. The z-th zero entry, counting from 0, uses reference index z when z < `num_ref` and 0 otherwise, and both directions carry that same index.
- R8: A zero entry has zero vectors in both directions, a list-0 flag of 1 and a list-1 flag equal to `slice_bi`.
- R9: An original entry copies its neighbour's prediction flags, reference indices and vectors for both directions unchanged.
- R10: While `out_valid` is low the data outputs keep the values of the last strobe, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; all other inputs are sampled with it |
| nb_valid | input | 7 | Neighbour available, bit i for neighbour i (order as in R2) |
| nb_pf_l0 | input | 7 | Neighbour predicts from list 0 |
| nb_pf_l1 | input | 7 | Neighbour predicts from list 1 |
| nb_ref_l0 | input | 7x4 | Neighbour list-0 reference indices |
| nb_ref_l1 | input | 7x4 | Neighbour list-1 reference indices |
| nb_mv_l0 | input | 7x32 | Neighbour list-0 vectors |
| nb_mv_l1 | input | 7x32 | Neighbour list-1 vectors |
| slice_bi | input | 1 | 1 for a bi-predictive slice, 0 for a uni-predictive slice |
| num_ref | input | 5 | Number of usable reference pictures |
| merge_idx | input | 3 | Selected list slot |
| out_valid | output | 1 | Result strobe |
| out_pf_l0 | output | 1 | Result list-0 prediction flag |
| out_pf_l1 | output | 1 | Result list-1 prediction flag |
| out_ref_l0 | output | 4 | Result list-0 reference index |
| out_ref_l1 | output | 4 | Result list-1 reference index |
| out_mv_l0 | output | 32 | Result list-0 vector |
| out_mv_l1 | output | 32 | Result list-1 vector |

## Verification
The latency properties look two cycles back, so they assume `in_valid` is held low while reset is asserted. The bench keeps it low from time zero until after reset is released, and it drives every input to a known value from the first cycle. The pairing properties assume that every available neighbour in a uni-predictive slice predicts from list 0 only. The stimulus enforces this and draws list-1 flags only in bi-predictive slices. The sweep covers every availability mask, both slice kinds, several reference counts and merge index values up to one beyond the list.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

    // Neighbour set: spatial first, then temporal
    localparam int NB_SPATIAL  = 5;
    localparam int NB_TEMPORAL = 2;
    localparam int NB          = NB_SPATIAL + NB_TEMPORAL;

    // Candidate list geometry
    localparam int DEPTH = 5;
    localparam int NPAIR = 12;

    // Field widths
    localparam int REF_W = 4;
    localparam int MV_W  = 16;
    localparam int MVP_W = 2 * MV_W;

    // Derived widths
    localparam int SRC_W = $clog2(NB + 1);
    localparam int CNT_W = $clog2(DEPTH + 1);

    // Source index one past the last neighbour stands for the zero vector
    localparam logic [SRC_W-1:0] ZERO_SRC = SRC_W'(NB);

    typedef logic [SRC_W-1:0] src_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [REF_W-1:0] ref_t;
    typedef logic [MVP_W-1:0] mv_t;

    // Per-slot mapping: where each direction comes from, flags, zero ref
    typedef struct packed {
        src_t src_l0;
        src_t src_l1;
        logic pf_l0;
        logic pf_l1;
        ref_t zref;
    } slot_map_t;

    // List position supplying list-0 motion for pair k
    function automatic int pair_first(input int k);
        case (k)
            0: return 0;  1: return 1;  2: return 0;  3: return 2;
            4: return 1;  5: return 2;  6: return 0;  7: return 3;
            8: return 1;  9: return 3;  10: return 2; default: return 3;
        endcase
    endfunction

    // List position supplying list-1 motion for pair k
    function automatic int pair_second(input int k);
        case (k)
            0: return 1;  1: return 0;  2: return 2;  3: return 0;
            4: return 2;  5: return 1;  6: return 3;  7: return 0;
            8: return 3;  9: return 1;  10: return 3; default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/mcm_orig_list.sv
module mcm_orig_list
    import mcm_pkg::*;
(
    input  logic [NB-1:0]    nb_valid,
    output src_t [DEPTH-1:0] orig_src,
    output cnt_t             orig_cnt
);

    // Compact the available neighbours, lowest index first, up to DEPTH
    always_comb begin
        orig_src = '0;
        orig_cnt = '0;
        for (int i = 0; i < NB; i++) begin
            if (nb_valid[i] && (orig_cnt < cnt_t'(DEPTH))) begin
                orig_src[orig_cnt] = src_t'(i);
                orig_cnt           = orig_cnt + cnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/mcm_comb_gen.sv
module mcm_comb_gen
    import mcm_pkg::*;
(
    input  logic             slice_bi,
    input  src_t [DEPTH-1:0] orig_src,
    input  cnt_t             orig_cnt,
    input  logic [NB-1:0]    nb_pf_l0,
    input  logic [NB-1:0]    nb_pf_l1,
    input  ref_t [NB-1:0]    nb_ref_l0,
    input  ref_t [NB-1:0]    nb_ref_l1,
    input  mv_t  [NB-1:0]    nb_mv_l0,
    input  mv_t  [NB-1:0]    nb_mv_l1,
    output src_t [DEPTH-1:0] comb_a,
    output src_t [DEPTH-1:0] comb_b,
    output cnt_t             comb_cnt
);

    int   n_orig;
    int   n_limit;
    src_t sa;
    src_t sb;
    logic differs;

    // Walk the fixed pair order; keep pairs that yield a new bi candidate
    always_comb begin
        comb_a   = '0;
        comb_b   = '0;
        comb_cnt = '0;
        sa       = '0;
        sb       = '0;
        differs  = 1'b0;
        n_orig   = int'(orig_cnt);
        n_limit  = n_orig * (n_orig - 1);
        for (int k = 0; k < NPAIR; k++) begin
            if (slice_bi && (n_orig > 1) && (k < n_limit)
                && ((n_orig + int'(comb_cnt)) < DEPTH)) begin
                sa      = orig_src[cnt_t'(pair_first(k))];
                sb      = orig_src[cnt_t'(pair_second(k))];
                differs = (nb_ref_l0[sa] != nb_ref_l1[sb])
                       || (nb_mv_l0[sa]  != nb_mv_l1[sb]);
                if (nb_pf_l0[sa] && nb_pf_l1[sb] && differs) begin
                    comb_a[comb_cnt] = sa;
                    comb_b[comb_cnt] = sb;
                    comb_cnt         = comb_cnt + cnt_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/mcm_slot_table.sv
module mcm_slot_table
    import mcm_pkg::*;
#(
    parameter int NREF_W = REF_W + 1
) (
    input  logic                  slice_bi,
    input  logic [NREF_W-1:0]     num_ref,
    input  src_t [DEPTH-1:0]      orig_src,
    input  cnt_t                  orig_cnt,
    input  src_t [DEPTH-1:0]      comb_a,
    input  src_t [DEPTH-1:0]      comb_b,
    input  cnt_t                  comb_cnt,
    input  logic [NB-1:0]         nb_pf_l0,
    input  logic [NB-1:0]         nb_pf_l1,
    output slot_map_t [DEPTH-1:0] slots
);

    int   n_o;
    int   n_oc;
    int   rel;
    src_t so;

    // Each slot is an original, a pair, or a zero entry, in that order
    always_comb begin
        n_o  = int'(orig_cnt);
        n_oc = n_o + int'(comb_cnt);
        rel  = 0;
        so   = '0;
        for (int s = 0; s < DEPTH; s++) begin
            slots[s] = '0;
            if (s < n_o) begin
                so              = orig_src[cnt_t'(s)];
                slots[s].src_l0 = so;
                slots[s].src_l1 = so;
                slots[s].pf_l0  = nb_pf_l0[so];
                slots[s].pf_l1  = nb_pf_l1[so];
            end else if (s < n_oc) begin
                rel             = s - n_o;
                slots[s].src_l0 = comb_a[cnt_t'(rel)];
                slots[s].src_l1 = comb_b[cnt_t'(rel)];
                slots[s].pf_l0  = 1'b1;
                slots[s].pf_l1  = 1'b1;
            end else begin
                rel             = s - n_oc;
                slots[s].src_l0 = ZERO_SRC;
                slots[s].src_l1 = ZERO_SRC;
                slots[s].pf_l0  = 1'b1;
                slots[s].pf_l1  = slice_bi;
                slots[s].zref   = (rel < int'(num_ref)) ? ref_t'(rel) : '0;
            end
        end
    end

endmodule

// File: rtl/mcm_dir_select.sv
module mcm_dir_select
    import mcm_pkg::*;
(
    input  src_t          src,
    input  ref_t          zref,
    input  ref_t [NB-1:0] bank_ref,
    input  mv_t  [NB-1:0] bank_mv,
    output ref_t          ref_o,
    output mv_t           mv_o
);

    // One (NB+1)-way selector: a neighbour or the zero vector
    always_comb begin
        if (src >= ZERO_SRC) begin
            ref_o = zref;
            mv_o  = '0;
        end else begin
            ref_o = bank_ref[src];
            mv_o  = bank_mv[src];
        end
    end

endmodule

// File: rtl/merge_index_mapper.sv
module merge_index_mapper
    import mcm_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int NREF_W = REF_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NB-1:0]              nb_valid,
    input  logic [NB-1:0]              nb_pf_l0,
    input  logic [NB-1:0]              nb_pf_l1,
    input  logic [NB-1:0][REF_W-1:0]   nb_ref_l0,
    input  logic [NB-1:0][REF_W-1:0]   nb_ref_l1,
    input  logic [NB-1:0][MVP_W-1:0]   nb_mv_l0,
    input  logic [NB-1:0][MVP_W-1:0]   nb_mv_l1,
    input  logic                       slice_bi,
    input  logic [NREF_W-1:0]          num_ref,
    input  logic [IDX_W-1:0]           merge_idx,
    output logic                       out_valid,
    output logic                       out_pf_l0,
    output logic                       out_pf_l1,
    output logic [REF_W-1:0]           out_ref_l0,
    output logic [REF_W-1:0]           out_ref_l1,
    output logic [MVP_W-1:0]           out_mv_l0,
    output logic [MVP_W-1:0]           out_mv_l1
);

    localparam int NDIR = 2;

    typedef struct packed {
        // stage 1: chosen mapping plus the motion bank it points into
        logic                     v1;
        slot_map_t                map1;
        logic [NB-1:0][REF_W-1:0] ref0;
        logic [NB-1:0][REF_W-1:0] ref1;
        logic [NB-1:0][MVP_W-1:0] mv0;
        logic [NB-1:0][MVP_W-1:0] mv1;
        // stage 2: resolved result
        logic                     v2;
        logic                     pf0;
        logic                     pf1;
        logic [REF_W-1:0]         r0;
        logic [REF_W-1:0]         r1;
        logic [MVP_W-1:0]         m0;
        logic [MVP_W-1:0]         m1;
    } state_t;

    state_t st_d, st_q;

    src_t [DEPTH-1:0]      orig_src;
    cnt_t                  orig_cnt;
    src_t [DEPTH-1:0]      comb_a;
    src_t [DEPTH-1:0]      comb_b;
    cnt_t                  comb_cnt;
    slot_map_t [DEPTH-1:0] slots;
    cnt_t                  sel_idx;
    slot_map_t             sel_map;

    src_t [NDIR-1:0]       dir_src;
    ref_t [NDIR-1:0]       dir_ref;
    mv_t  [NDIR-1:0]       dir_mv;

    mcm_orig_list u_orig (
        .nb_valid (nb_valid),
        .orig_src (orig_src),
        .orig_cnt (orig_cnt)
    );

    mcm_comb_gen u_comb (
        .slice_bi  (slice_bi),
        .orig_src  (orig_src),
        .orig_cnt  (orig_cnt),
        .nb_pf_l0  (nb_pf_l0),
        .nb_pf_l1  (nb_pf_l1),
        .nb_ref_l0 (nb_ref_l0),
        .nb_ref_l1 (nb_ref_l1),
        .nb_mv_l0  (nb_mv_l0),
        .nb_mv_l1  (nb_mv_l1),
        .comb_a    (comb_a),
        .comb_b    (comb_b),
        .comb_cnt  (comb_cnt)
    );

    mcm_slot_table #(
        .NREF_W (NREF_W)
    ) u_table (
        .slice_bi (slice_bi),
        .num_ref  (num_ref),
        .orig_src (orig_src),
        .orig_cnt (orig_cnt),
        .comb_a   (comb_a),
        .comb_b   (comb_b),
        .comb_cnt (comb_cnt),
        .nb_pf_l0 (nb_pf_l0),
        .nb_pf_l1 (nb_pf_l1),
        .slots    (slots)
    );

    // Saturate the index at the last slot
    always_comb begin
        if (int'(merge_idx) > DEPTH - 1) begin
            sel_idx = cnt_t'(DEPTH - 1);
        end else begin
            sel_idx = cnt_t'(merge_idx);
        end
        sel_map = slots[sel_idx];
    end

    // Per-direction selectors fed from the stage-1 registers
    assign dir_src[0] = st_q.map1.src_l0;
    assign dir_src[1] = st_q.map1.src_l1;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        mcm_dir_select u_sel (
            .src      (dir_src[d]),
            .zref     (st_q.map1.zref),
            .bank_ref ((d == 0) ? st_q.ref0 : st_q.ref1),
            .bank_mv  ((d == 0) ? st_q.mv0  : st_q.mv1),
            .ref_o    (dir_ref[d]),
            .mv_o     (dir_mv[d])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.map1 = sel_map;
            st_d.ref0 = nb_ref_l0;
            st_d.ref1 = nb_ref_l1;
            st_d.mv0  = nb_mv_l0;
            st_d.mv1  = nb_mv_l1;
        end
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.pf0 = st_q.map1.pf_l0;
            st_d.pf1 = st_q.map1.pf_l1;
            st_d.r0  = dir_ref[0];
            st_d.r1  = dir_ref[1];
            st_d.m0  = dir_mv[0];
            st_d.m1  = dir_mv[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.v2;
    assign out_pf_l0  = st_q.pf0;
    assign out_pf_l1  = st_q.pf1;
    assign out_ref_l0 = st_q.r0;
    assign out_ref_l1 = st_q.r1;
    assign out_mv_l0  = st_q.m0;
    assign out_mv_l1  = st_q.m1;

    // ---------------- assertions ----------------

    AST_OUT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R1

    AST_REQ_GIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid, 2) |-> out_valid); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_mv_l0) && $stable(out_mv_l1)
                        && $stable(out_ref_l0) && $stable(out_ref_l1)
                        && $stable(out_pf_l0) && $stable(out_pf_l1))); // R10

    AST_COMB_BI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_cnt != '0) |-> (slice_bi && (orig_cnt > cnt_t'(1)))); // R4

    AST_LIST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((int'(orig_cnt) + int'(comb_cnt)) <= DEPTH)); // R4

    AST_COMB_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (sel_map.src_l0 != sel_map.src_l1))
        |-> (nb_pf_l0[sel_map.src_l0] && nb_pf_l1[sel_map.src_l1]
             && ((nb_ref_l0[sel_map.src_l0] != nb_ref_l1[sel_map.src_l1])
                 || (nb_mv_l0[sel_map.src_l0] != nb_mv_l1[sel_map.src_l1])))); // R5

    AST_ZERO_REF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (sel_map.src_l0 == ZERO_SRC))
        |-> ((int'(sel_map.zref) < int'(num_ref)) || (sel_map.zref == '0))); // R7

endmodule

// File: tb/test_merge_index_mapper.sv
module test_merge_index_mapper;
    import mcm_pkg::*;

    localparam int BW = 2 + 2 * REF_W + 2 * MVP_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic [NB-1:0]            nb_valid = '0;
    logic [NB-1:0]            nb_pf_l0 = '0;
    logic [NB-1:0]            nb_pf_l1 = '0;
    logic [NB-1:0][REF_W-1:0] nb_ref_l0 = '0;
    logic [NB-1:0][REF_W-1:0] nb_ref_l1 = '0;
    logic [NB-1:0][MVP_W-1:0] nb_mv_l0 = '0;
    logic [NB-1:0][MVP_W-1:0] nb_mv_l1 = '0;
    logic                     slice_bi = 1'b0;
    logic [REF_W:0]           num_ref = '0;
    logic [2:0]               merge_idx = '0;
    logic                     out_valid;
    logic                     out_pf_l0;
    logic                     out_pf_l1;
    logic [REF_W-1:0]         out_ref_l0;
    logic [REF_W-1:0]         out_ref_l1;
    logic [MVP_W-1:0]         out_mv_l0;
    logic [MVP_W-1:0]         out_mv_l1;

    merge_index_mapper i_merge_index_mapper (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .nb_valid   (nb_valid),
        .nb_pf_l0   (nb_pf_l0),
        .nb_pf_l1   (nb_pf_l1),
        .nb_ref_l0  (nb_ref_l0),
        .nb_ref_l1  (nb_ref_l1),
        .nb_mv_l0   (nb_mv_l0),
        .nb_mv_l1   (nb_mv_l1),
        .slice_bi   (slice_bi),
        .num_ref    (num_ref),
        .merge_idx  (merge_idx),
        .out_valid  (out_valid),
        .out_pf_l0  (out_pf_l0),
        .out_pf_l1  (out_pf_l1),
        .out_ref_l0 (out_ref_l0),
        .out_ref_l1 (out_ref_l1),
        .out_mv_l0  (out_mv_l0),
        .out_mv_l1  (out_mv_l1)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] seed = 32'h1357_9bdf;

    int pa[NPAIR] = '{0, 1, 0, 2, 1, 2, 0, 3, 1, 3, 2, 3};
    int pb[NPAIR] = '{1, 0, 2, 0, 2, 1, 3, 0, 3, 1, 3, 2};
    logic [MVP_W-1:0] mvtab[4] = '{32'h0000_0000, 32'h0005_fffd, 32'h0005_0005, 32'hfff0_0002};
    int nrtab[3] = '{1, 2, 4};

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [BW-1:0] act_bundle();
        return {out_pf_l0, out_pf_l1, out_ref_l0, out_ref_l1, out_mv_l0, out_mv_l1};
    endfunction

    task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // New neighbour content; a uni slice has list-0 prediction only
    task automatic fill_neighbours(input bit bi);
        logic [31:0] r;
        for (int i = 0; i < NB; i++) begin
            r = rnd();
            if (!bi) begin
                nb_pf_l0[i] = 1'b1;
                nb_pf_l1[i] = 1'b0;
            end else begin
                case (r % 3)
                    0: begin nb_pf_l0[i] = 1'b1; nb_pf_l1[i] = 1'b0; end
                    1: begin nb_pf_l0[i] = 1'b0; nb_pf_l1[i] = 1'b1; end
                    default: begin nb_pf_l0[i] = 1'b1; nb_pf_l1[i] = 1'b1; end
                endcase
            end
            nb_ref_l0[i] = REF_W'((r >> 4) & 1);
            nb_ref_l1[i] = REF_W'((r >> 5) & 1);
            nb_mv_l0[i]  = mvtab[(r >> 8) & 3];
            nb_mv_l1[i]  = mvtab[(r >> 10) & 3];
        end
    endtask

    // Reference list built from the requirements
    function automatic logic [BW-1:0] expect_out(input int midx, output string tag);
        int ls[DEPTH];
        logic ep0[DEPTH];
        logic ep1[DEPTH];
        logic [REF_W-1:0] er0[DEPTH];
        logic [REF_W-1:0] er1[DEPTH];
        logic [MVP_W-1:0] em0[DEPTH];
        logic [MVP_W-1:0] em1[DEPTH];
        string et[DEPTH];
        int n;
        int cnt;
        int z;
        int a;
        int b;
        int pick;
        n = 0;
        for (int i = 0; i < NB; i++) begin
            if (nb_valid[i] && n < DEPTH) begin
                ls[n] = i;
                n++;
            end
        end
        for (int s = 0; s < n; s++) begin
            ep0[s] = nb_pf_l0[ls[s]]; ep1[s] = nb_pf_l1[ls[s]];
            er0[s] = nb_ref_l0[ls[s]]; er1[s] = nb_ref_l1[ls[s]];
            em0[s] = nb_mv_l0[ls[s]]; em1[s] = nb_mv_l1[ls[s]];
            et[s]  = "R2 R9";
        end
        cnt = n;
        if (slice_bi && n > 1) begin
            for (int k = 0; k < NPAIR && k < n * (n - 1) && cnt < DEPTH; k++) begin
                a = ls[pa[k]];
                b = ls[pb[k]];
                if (nb_pf_l0[a] && nb_pf_l1[b]
                    && (nb_ref_l0[a] != nb_ref_l1[b] || nb_mv_l0[a] != nb_mv_l1[b])) begin
                    ep0[cnt] = 1'b1; ep1[cnt] = 1'b1;
                    er0[cnt] = nb_ref_l0[a]; er1[cnt] = nb_ref_l1[b];
                    em0[cnt] = nb_mv_l0[a]; em1[cnt] = nb_mv_l1[b];
                    et[cnt]  = "R4 R5 R6";
                    cnt++;
                end
            end
        end
        z = 0;
        while (cnt < DEPTH) begin
            ep0[cnt] = 1'b1; ep1[cnt] = slice_bi;
            er0[cnt] = (z < int'(num_ref)) ? REF_W'(z) : '0;
            er1[cnt] = er0[cnt];
            em0[cnt] = '0; em1[cnt] = '0;
            et[cnt]  = "R7 R8";
            z++;
            cnt++;
        end
        pick = (midx > DEPTH - 1) ? DEPTH - 1 : midx;
        tag  = (midx > DEPTH - 1) ? {"R3 ", et[pick]} : et[pick];
        return {ep0[pick], ep1[pick], er0[pick], er1[pick], em0[pick], em1[pick]};
    endfunction

    initial begin
        logic [BW-1:0] exp;
        logic [BW-1:0] held;
        string tag;
        repeat (3) @(negedge clk);
        check("R1 reset", {out_valid, act_bundle()}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int vm = 0; vm < (1 << NB); vm++) begin
            for (int sb = 0; sb < 2; sb++) begin
                for (int nr = 0; nr < 3; nr++) begin
                    for (int mi = 0; mi < DEPTH + 1; mi++) begin
                        nb_valid  = NB'(vm);
                        slice_bi  = sb[0];
                        num_ref   = (REF_W + 1)'(nrtab[nr]);
                        merge_idx = 3'(mi);
                        fill_neighbours(sb[0]);
                        exp = expect_out(mi, tag);
                        in_valid = 1'b1;
                        @(negedge clk);
                        in_valid = 1'b0;
                        check("R1 early strobe", BW'(out_valid), BW'(0));
                        @(negedge clk);
                        check("R1 strobe", BW'(out_valid), BW'(1));
                        check(tag, act_bundle(), exp);
                        held = act_bundle();
                        fill_neighbours(sb[0]);
                        nb_valid  = ~NB'(vm);
                        merge_idx = 3'(DEPTH - 1 - (mi % DEPTH));
                        @(negedge clk);
                        check("R1 single strobe", BW'(out_valid), BW'(0));
                        check("R10 hold", act_bundle(), held);
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule